// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block is a synthesizable target-side model of a byte-addressed serial EEPROM on a two-wire bus. It oversamples the clock and data lines with the system clock, recognises start and stop conditions, shifts in 8-bit words on rising bus-clock edges, and answers each accepted word by pulling the data line low during the ninth clock. Read data leaves most significant bit first. It is launched after falling bus-clock edges through an open-drain enable that can only pull the line low.

The storage is a register array. Writes first collect in a page buffer, which can be partly filled. A valid stop after a write sequence starts a self-timed write cycle of `WRITE_CYCLES` system clocks. During that cycle the target ignores its own device address, and it moves the buffered bytes into the array when the cycle ends. `MEM_BYTES` selects the density:
- the page size, 8 bytes up to 256 bytes and 16 bytes above that;
- how many of the three address pins take part in the device-address compare;
- whether write protect covers the whole array or only the upper half, which applies at 2048 bytes.

Top module: `twi_eeprom_target`

## Requirements
- R1: A start (data falling while clock high) opens a transaction. A stop (data rising while clock high) ends it and leaves the enable released. Clock pulses that arrive after a stop and before the next start get no acknowledge.
- R2: The first word after a start is the device byte {4'b1010, three address bits, R/W}. At the default density all three address bits must equal `dev_pins_i`, and only then does the target acknowledge. Any other device byte is not acknowledged.
- R3: The enable changes only while the bus clock is low. Read bytes are sent most significant bit first.
- R4: A write sequence sends a device byte with R/W=0, then a word address, then data. A random read is a dummy write of the word address, then a repeated start and a device byte with R/W=1. The random read returns the byte written earlier.
- R5: During a page write the low address bits (3 bits at the default density) wrap inside the 8-byte page.
- R6: A write of fewer bytes than a page changes only the bytes that were sent. An unwritten location reads 8'hFF.
- R7: A sequential read advances the address across the whole array and rolls over from the top address to 0.
- R8: A stop after at least one data byte starts the write cycle. The array is updated when the cycle ends. A stop after only a word address starts no cycle.
- R9: While the write cycle runs, the device byte is not acknowledged.
- R10: When `wp_i` is high at the stop, a write at the default density starts no cycle and changes no byte.
- R11: A start in the middle of a word aborts that word and returns to device-address reception. Bytes buffered before the start are discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| wp_i | input | 1 | Write protect, high blocks writes |
| dev_pins_i | input | 3 | Hard-wired device address pins |
| sda_oe_o | output | 1 | Open-drain enable, 1 pulls the data line low |

## Verification
The embedded properties assume three things about the bus lines. Each line holds still for several system clocks around every edge, so the synchronizer sees a clean sequence of levels. Data changes only while the clock is low, except for deliberate starts and stops. The controller never drives the data line low against the target's released state when a stop is intended. The bench toggles both lines on falling system-clock edges, in quarter-bit steps of eight system clocks, which is well above the synchronizer delay. The target's pull-down is modelled as a wired AND with the controller's drive, so acknowledges and read bits are sampled from the resolved line while the clock is high.

// File: rtl/twi_eeprom_target.sv
module twi_eeprom_target #(
  parameter int MEM_BYTES    = 256,
  parameter int WRITE_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       wp_i,
  input  logic [2:0] dev_pins_i,
  output logic       sda_oe_o
);
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int PAGE = (MEM_BYTES <= 256) ? 8 : 16;
  localparam int PW   = $clog2(PAGE);
  localparam int NPIN = (AW > 8) ? (11 - AW) : 3;
  localparam logic [2:0] PIN_MASK = 3'((7 << (3 - NPIN)) & 7);
  localparam bit HALF_WP = (MEM_BYTES == 2048);
  localparam int CW   = $clog2(WRITE_CYCLES + 1);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_ACKW, S_ACK, S_TX, S_MACK, S_MACKF} st_t;
  typedef enum logic [1:0] {PH_DEV, PH_WORD, PH_DATA, PH_RD} ph_t;

  logic [2:0]    scl_p, sda_p;
  st_t           st;
  ph_t           ph;
  logic [2:0]    bitcnt;
  logic [7:0]    rx_sr, tx_sr;
  logic [2:0]    dev_hi;
  logic [AW-1:0] ptr;
  logic [7:0]    pbuf [PAGE];
  logic [PAGE-1:0] pvld;
  logic          busy;
  logic [CW-1:0] busy_cnt;
  logic [7:0]    mem [MEM_BYTES];

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];
  wire start_det = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_det  = scl_s & scl_q & ~sda_q & sda_s;
  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;

  wire [7:0]  rx_byte   = {rx_sr[6:0], sda_s};
  wire [10:0] full_addr = {dev_hi, rx_byte};
  wire        dev_match = (rx_byte[7:4] == 4'hA) &&
                          (((rx_byte[3:1] ^ dev_pins_i) & PIN_MASK) == 3'b000);
  wire        prot      = wp_i & (HALF_WP ? ptr[AW-1] : 1'b1);
  wire        commit    = busy && (busy_cnt == CW'(1));
  wire [7:0]  rd_byte   = mem[ptr];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= PH_DEV;
      bitcnt   <= '0;
      rx_sr    <= '0;
      tx_sr    <= '0;
      dev_hi   <= '0;
      ptr      <= '0;
      pvld     <= '0;
      busy     <= 1'b0;
      busy_cnt <= '0;
      sda_oe_o <= 1'b0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= '0;
    end else begin
      if (busy) begin
        busy_cnt <= busy_cnt - 1'b1;
        if (commit) begin
          busy <= 1'b0;
          pvld <= '0;
        end
      end
      if (start_det) begin
        st       <= S_RX;
        ph       <= PH_DEV;
        bitcnt   <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_det) begin
        st       <= S_IDLE;
        ph       <= PH_DEV;
        sda_oe_o <= 1'b0;
        if (ph == PH_DATA && (|pvld) && !prot) begin
          busy     <= 1'b1;
          busy_cnt <= CW'(WRITE_CYCLES);
        end
      end else begin
        case (st)
          S_RX: if (scl_rise) begin
            rx_sr  <= rx_byte;
            bitcnt <= bitcnt + 1'b1;
            if (bitcnt == 3'd7) begin
              case (ph)
                PH_DEV: if (dev_match && !busy) begin
                  dev_hi <= rx_byte[3:1];
                  ph     <= rx_byte[0] ? PH_RD : PH_WORD;
                  st     <= S_ACKW;
                end else st <= S_IDLE;
                PH_WORD: begin
                  ptr  <= full_addr[AW-1:0];
                  pvld <= '0;
                  ph   <= PH_DATA;
                  st   <= S_ACKW;
                end
                PH_DATA: begin
                  pbuf[ptr[PW-1:0]] <= rx_byte;
                  pvld[ptr[PW-1:0]] <= 1'b1;
                  ptr[PW-1:0]       <= ptr[PW-1:0] + 1'b1;
                  st                <= S_ACKW;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
          S_ACKW: if (scl_fall) begin
            sda_oe_o <= 1'b1;
            st       <= S_ACK;
          end
          S_ACK, S_MACKF: if (scl_fall) begin
            if (ph == PH_RD) begin
              tx_sr    <= rd_byte;
              sda_oe_o <= ~rd_byte[7];
              bitcnt   <= '0;
              st       <= S_TX;
            end else begin
              sda_oe_o <= 1'b0;
              bitcnt   <= '0;
              st       <= S_RX;
            end
          end
          S_TX: if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe_o <= 1'b0;
              ptr      <= ptr + 1'b1;
              bitcnt   <= '0;
              st       <= S_MACK;
            end else begin
              tx_sr    <= {tx_sr[6:0], 1'b0};
              sda_oe_o <= ~tx_sr[6];
              bitcnt   <= bitcnt + 1'b1;
            end
          end
          S_MACK: if (scl_rise) st <= sda_s ? S_IDLE : S_MACKF;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
    end else begin
      for (int i = 0; i < PAGE; i++)
        if (commit && pvld[i]) mem[{ptr[AW-1:PW], PW'(i)}] <= pbuf[i];
    end

  p_oe_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> $past(!scl_s));

  p_busy_from_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_det));

  p_busy_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st != S_ACKW && st != S_TX));

  p_start_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_RX && ph == PH_DEV && !sda_oe_o));

  p_tx_read_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX) |-> (ph == PH_RD));

  p_wp_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !($past(wp_i) && (!HALF_WP || $past(ptr[AW-1]))));
endmodule

// File: tb/twi_eeprom_target_tb_top.sv
module twi_eeprom_target_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  int   n_chk = 0;
  int   n_fail = 0;
  int   viol = 0;
  bit   done = 1'b0;

  localparam logic [7:0] DEV_W = 8'hAA;
  localparam logic [7:0] DEV_R = 8'hAB;
  localparam logic [15:0] VEC [6] = '{16'h003C, 16'hFFA5, 16'h7F01,
                                      16'h80FE, 16'h425A, 16'h10C3};

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_eeprom_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .wp_i(wp), .dev_pins_i(3'b101), .sda_oe_o(sda_oe));

  logic oe_prev = 1'b0;
  logic scl_prev = 1'b1;
  always @(negedge clk) begin
    if (scl_m && scl_prev && sda_oe != oe_prev) viol++;
    oe_prev  <= sda_oe;
    scl_prev <= scl_m;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (8) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
    end
    wq(); sda_m = ~mack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq(); sda_m = 1'b1;
  endtask

  task automatic wr_bytes(input logic [7:0] a, input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3, input int n,
                          output bit all_ack);
    bit k;
    b_start();
    send_byte(DEV_W, k); all_ack = k;
    send_byte(a, k); all_ack &= k;
    if (n > 0) begin send_byte(d0, k); all_ack &= k; end
    if (n > 1) begin send_byte(d1, k); all_ack &= k; end
    if (n > 2) begin send_byte(d2, k); all_ack &= k; end
    if (n > 3) begin send_byte(d3, k); all_ack &= k; end
    b_stop();
  endtask

  task automatic poll(output bit ack);
    b_start(); send_byte(DEV_W, ack); b_stop();
  endtask

  task automatic wait_ready();
    bit k = 1'b0;
    for (int i = 0; i < 20 && !k; i++) poll(k);
  endtask

  logic [7:0] rb [8];
  task automatic rd_seq(input logic [7:0] a, input int n, output bit all_ack);
    bit k;
    b_start();
    send_byte(DEV_W, k); all_ack = k;
    send_byte(a, k); all_ack &= k;
    b_start();
    send_byte(DEV_R, k); all_ack &= k;
    for (int i = 0; i < n; i++) recv_byte(i != n - 1, rb[i]);
    b_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] exp8 [8];
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R1 reset release", sda_oe, 0);
    rst_n = 1'b1;
    wq();
    chk(sda_line == 1'b1, "R1 idle line high", sda_line, 1);

    // R4 table walk: write then random read back
    for (int v = 0; v < 6; v++) begin
      wr_bytes(VEC[v][15:8], VEC[v][7:0], 8'h0, 8'h0, 8'h0, 1, ak);
      chk(ak, "R4 write acks", ak, 1);
      wait_ready();
      rd_seq(VEC[v][15:8], 1, ak);
      chk(ak && rb[0] == VEC[v][7:0], "R4 R3 readback", rb[0], VEC[v][7:0]);
    end

    // R2 device address compare
    b_start(); send_byte(8'hA0, ak); b_stop();
    chk(!ak, "R2 pin mismatch nack", ak, 0);
    b_start(); send_byte(8'hBA, ak); b_stop();
    chk(!ak, "R2 wrong type nack", ak, 0);
    poll(ak);
    chk(ak, "R2 match ack", ak, 1);

    // R1 clocks without start are ignored
    send_byte(8'hAA, ak);
    chk(!ak && sda_oe == 1'b0, "R1 no start no ack", ak, 0);

    // R8 R9 write cycle busy and commit
    wr_bytes(8'h20, 8'h77, 8'h0, 8'h0, 8'h0, 1, ak);
    poll(ak);
    chk(!ak, "R9 busy nack", ak, 0);
    wait_ready();
    rd_seq(8'h20, 1, ak);
    chk(rb[0] == 8'h77, "R8 committed", rb[0], 8'h77);
    wr_bytes(8'h30, 8'h0, 8'h0, 8'h0, 8'h0, 0, ak);
    poll(ak);
    chk(ak, "R8 no cycle after address-only write", ak, 1);

    // R5 R6 page wrap and partial page
    wr_bytes(8'h1E, 8'h11, 8'h22, 8'h33, 8'h44, 4, ak);
    wait_ready();
    rd_seq(8'h18, 8, ak);
    exp8 = '{8'h33, 8'h44, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h11, 8'h22};
    for (int i = 0; i < 8; i++)
      chk(rb[i] == exp8[i], (i < 2 || i > 5) ? "R5 page wrap" : "R6 partial page", rb[i], exp8[i]);

    // R7 sequential read rollover
    rd_seq(8'hFE, 4, ak);
    exp8[0] = 8'hFF; exp8[1] = 8'hA5; exp8[2] = 8'h3C; exp8[3] = 8'hFF;
    for (int i = 0; i < 4; i++)
      chk(rb[i] == exp8[i], "R7 rollover", rb[i], exp8[i]);

    // R10 write protect
    wp = 1'b1;
    wr_bytes(8'h42, 8'h99, 8'h0, 8'h0, 8'h0, 1, ak);
    poll(ak);
    chk(ak, "R10 no cycle under protect", ak, 1);
    rd_seq(8'h42, 1, ak);
    chk(rb[0] == 8'h5A, "R10 byte kept", rb[0], 8'h5A);
    wp = 1'b0;

    // R11 start mid-word aborts
    b_start();
    send_byte(DEV_W, ak); send_byte(8'h50, ak); send_byte(8'h66, ak);
    send_bits(8'hF0, 4);
    b_start();
    send_byte(DEV_W, ak);
    b_stop();
    chk(ak, "R11 restart ack and no cycle", ak, 1);
    rd_seq(8'h50, 1, ak);
    chk(rb[0] == 8'hFF, "R11 aborted data dropped", rb[0], 8'hFF);

    chk(viol == 0, "R3 enable stable while clock high", viol, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule